// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block is a watchdog timer peripheral. Software sets it up through a single-cycle register write port, and the block exposes two readable registers. The control register holds the enable, the timeout select and a self-clearing change-enable bit. The status register holds reset-cause flags. A tick-enable input advances a timeout counter. A kick input clears that counter. If the count reaches the selected limit while the watchdog is on, the block pulses a reset request for one cycle and records a watchdog reset in the status register.

Switching the watchdog on is always allowed. Switching it off, or selecting a different timeout, takes two writes. The first write, the arm write, sets change-enable and enable together. The second write, the commit write, carries the wanted enable and timeout values with change-enable clear, and it must arrive within four clock cycles of the arm write. A small state machine guards this sequence. It has two states. In LOCKED, the protected fields cannot be changed. In OPEN, the window for the commit write is running.

The transitions are named as follows:
- ARM: LOCKED to OPEN, on an arm write.
- REARM: OPEN to OPEN, on another arm write, which restarts the window.
- COMMIT: OPEN to LOCKED, on a commit write.
- ABORT: OPEN to LOCKED, on a control write that sets change-enable but clears enable.
- EXPIRE: OPEN to LOCKED, when four cycles pass without a control write.

Top module: `wdt_guarded`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00 and `rst_req` is low.
- R2: A control write with bit 3 (enable) set turns the watchdog on, whatever the state of the guard.
- R3: In LOCKED, a control write leaves the timeout select unchanged and cannot clear the enable. Bit 6 (interrupt-enable storage) still takes the written value.
- R4: A control write with bit 4 (change-enable) and bit 3 both set performs ARM (or REARM). Change-enable then reads 1 in control bit 4.
- R5: A control write with bit 4 clear, made on any of the four clock edges after the ARM edge, performs COMMIT. The enable takes bit 3. The 4-bit timeout select takes {bit 5, bits 2:0}.
- R6: Without a control write, EXPIRE clears change-enable on the fourth edge after ARM. A commit write on the fifth edge is then ignored.
- R7: While enabled, after 2^(BASE_LOG2+code) tick-enable cycles counted since the count was last cleared, `rst_req` is high for exactly one cycle, and the count restarts.
- R8: A kick, or a COMMIT that changes the timeout select, clears the count. A kick takes priority over a terminal tick in the same cycle.
- R9: Timeout select codes 10 to 15 give the same timeout as code 9.
- R10: A timeout sets status bit 3 in the same edge as `rst_req` rises. A status write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A set and a clear in the same cycle leave the flag set.
- R11: `cause_in` bits 3, 2, 1 and 0 set status bits 4 (debug-port), 2 (brown-out), 1 (external) and 0 (power-on).
- R12: Control bit 7 and status bits 7:5 always read 0. ABORT leaves the enable and the timeout select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_sel | input | 1 | Write target: 0 selects control, 1 selects status |
| bus_wdata | input | 8 | Write data |
| kick | input | 1 | Clears the timeout count |
| tick | input | 1 | Tick enable that advances the timeout count |
| cause_in | input | 4 | Other reset-cause set pulses {debug-port, brown-out, external, power-on} |
| ctrl_rd | output | 8 | Control register {0, ie, sel[3], ce, en, sel[2:0]} |
| stat_rd | output | 8 | Status register {000, debug, watchdog, brown-out, external, power-on} |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
Every register change, including the change-enable bit, is visible on `ctrl_rd` and `stat_rd` one edge after the write. `rst_req` and status bit 3 rise in the edge that consumes the terminal tick. The bench drives inputs at the falling edge and steps a bench model at the rising edge. It compares all three outputs at the following falling edge, so each result is checked in the cycle it becomes due. Directed cases place the commit write on the fourth and on the fifth edge after ARM. They also count ticks to the exact timeout edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic {
        WIN_LOCKED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_e;

    localparam int CODE_W    = 4;
    localparam int CODE_LAST = 9;
    localparam int FLAG_W    = 5;
    localparam int FLAG_WD   = 3;
endpackage

// File: rtl/wdg_unlock_fsm.sv
module wdg_unlock_fsm
    import wdg_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ce_bit,
    input  logic en_bit,
    output logic is_open,
    output logic commit
);
    localparam int WW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);

    win_state_e st_q, st_d;
    logic [WW-1:0] win_q;
    logic arm;

    assign arm = ctrl_wr && ce_bit && en_bit;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WIN_LOCKED: if (arm) st_d = WIN_OPEN;
            WIN_OPEN: begin
                if (ctrl_wr)               st_d = arm ? WIN_OPEN : WIN_LOCKED;
                else if (win_q == WIN_LAST) st_d = WIN_LOCKED;
            end
            default: st_d = WIN_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WIN_LOCKED;
            win_q <= '0;
        end else begin
            st_q  <= st_d;
            win_q <= (arm || st_q == WIN_LOCKED) ? '0 : win_q + 1'b1;
        end
    end

    always_comb begin
        is_open = (st_q == WIN_OPEN);
        commit  = (st_q == WIN_OPEN) && ctrl_wr && !ce_bit;
    end

    // R6: the window never outlives its last cycle
    a_r6_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WIN_OPEN && win_q == WIN_LAST && !ctrl_wr) |=> (st_q == WIN_LOCKED));
    // R4: an arm write always leaves the guard open
    a_r4_arm_opens: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (st_q == WIN_OPEN));
endmodule

// File: rtl/wdg_timeout.sv
module wdg_timeout
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              hit,
    output logic              rst_req
);
    localparam int CW = BASE_LOG2 + CODE_LAST + 1;

    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     last;
    logic [CODE_W-1:0] code_eff;

    always_comb begin
        code_eff = (code > CODE_W'(CODE_LAST)) ? CODE_W'(CODE_LAST) : code;
        last     = (CW'(1) << (BASE_LOG2 + int'(code_eff))) - CW'(1);
        hit      = en && !clr && tick && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= hit;
            if (!en || clr)  cnt_q <= '0;
            else if (tick)   cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    // R7: the reset request is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R8: a kick while enabled restarts the count
    a_r8_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_causes.sv
module wdg_causes
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [FLAG_W-1:0] wdata,
    input  logic              wd_set,
    input  logic [3:0]        src_set,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] set_v;

    assign set_v = {src_set[3], wd_set, src_set[2:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (wr ? (flags & wdata) : flags) | set_v;
    end

    // R10: a watchdog event always leaves its flag set
    a_r10_wd_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wd_set |=> flags[FLAG_WD]);
endmodule

// File: rtl/wdt_guarded.sv
module wdt_guarded
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int WIN_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    input  logic       kick,
    input  logic       tick,
    input  logic [3:0] cause_in,
    output logic [7:0] ctrl_rd,
    output logic [7:0] stat_rd,
    output logic       rst_req
);
    logic              ctrl_wr, stat_wr;
    logic              en_q, ie_q;
    logic [CODE_W-1:0] sel_q, sel_new;
    logic              is_open, commit, sel_chg, hit;
    logic [FLAG_W-1:0] flags;

    assign ctrl_wr = bus_wr && !bus_sel;
    assign stat_wr = bus_wr && bus_sel;
    assign sel_new = {bus_wdata[5], bus_wdata[2:0]};
    assign sel_chg = commit && (sel_new != sel_q);

    wdg_unlock_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .ce_bit(bus_wdata[4]), .en_bit(bus_wdata[3]),
        .is_open(is_open), .commit(commit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ie_q  <= 1'b0;
            sel_q <= '0;
        end else if (ctrl_wr) begin
            ie_q <= bus_wdata[6];
            if (commit) begin
                en_q  <= bus_wdata[3];
                sel_q <= sel_new;
            end else begin
                en_q  <= en_q | bus_wdata[3];
            end
        end
    end

    wdg_timeout #(.BASE_LOG2(BASE_LOG2)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(en_q), .clr(kick || sel_chg),
        .tick(tick), .code(sel_q), .hit(hit), .rst_req(rst_req)
    );

    wdg_causes u_cause (
        .clk(clk), .rst_n(rst_n), .wr(stat_wr), .wdata(bus_wdata[FLAG_W-1:0]),
        .wd_set(hit), .src_set(cause_in), .flags(flags)
    );

    assign ctrl_rd = {1'b0, ie_q, sel_q[3], is_open, en_q, sel_q[2:0]};
    assign stat_rd = {3'b000, flags};

    // R3: outside the window the timeout select cannot move
    a_r3_locked_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !is_open) |=> $stable(sel_q));
    // R3: outside the window the enable cannot fall
    a_r3_locked_en: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !is_open && en_q) |=> en_q);
    // R2: writing enable as one always turns the watchdog on
    a_r2_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[3]) |=> en_q);
    // R10: the reset request is accompanied by its flag
    a_r10_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> stat_rd[FLAG_WD]);
endmodule

// File: tb/wdt_guarded_test.sv
`timescale 1ns/1ps
module wdt_guarded_test;
    localparam int B = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr = 1'b0, sel = 1'b0, kk = 1'b0, tk = 1'b0;
    logic [7:0] d = 8'h00;
    logic [3:0] cs = 4'h0;
    logic [7:0] ctrl_rd, stat_rd;
    logic rst_req;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic m_en = 0, m_ie = 0, m_open = 0, m_req = 0;
    logic [3:0] m_ps = 0;
    logic [4:0] m_fl = 0;
    int m_win = 0, m_cnt = 0;

    always #4 clk = ~clk;

    wdt_guarded #(.BASE_LOG2(B), .WIN_CYC(4)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_sel(sel), .bus_wdata(d),
        .kick(kk), .tick(tk), .cause_in(cs),
        .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .rst_req(rst_req)
    );

    function automatic int lim(input logic [3:0] c);
        return 4 << ((c > 9) ? 9 : int'(c));
    endfunction

    function automatic logic [7:0] exp_ctrl();
        return {1'b0, m_ie, m_ps[3], m_open, m_en, m_ps[2:0]};
    endfunction

    task automatic model_step();
        logic clr = kk;
        logic n_en = m_en, n_open = m_open;
        logic [3:0] n_ps = m_ps;
        int n_win = m_win;
        if (wr && !sel) begin
            m_ie = d[6];
            if (m_open && !d[4]) begin
                if ({d[5], d[2:0]} != m_ps) clr = 1;
                n_en = d[3]; n_ps = {d[5], d[2:0]}; n_open = 0;
            end else begin
                n_en = m_en | d[3];
                if (d[4] && d[3]) begin n_open = 1; n_win = 0; end
                else if (m_open) n_open = 0;
            end
        end else if (m_open) begin
            if (m_win == 3) n_open = 0; else n_win = m_win + 1;
        end
        m_req = 0;
        if (!m_en || clr) m_cnt = 0;
        else if (tk) begin
            if (m_cnt == lim(m_ps) - 1) begin m_cnt = 0; m_req = 1; end
            else m_cnt++;
        end
        if (wr && sel) m_fl = m_fl & d[4:0];
        m_fl = m_fl | {cs[3], m_req, cs[2:0]};
        m_en = n_en; m_ps = n_ps; m_open = n_open; m_win = n_win;
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic w, input logic s, input logic [7:0] dd,
                        input logic k, input logic t, input logic [3:0] c, input string tag);
        wr = w; sel = s; d = dd; kk = k; tk = t; cs = c;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " ctrl"}, ctrl_rd, exp_ctrl());
        chk({tag, " stat"}, stat_rd, {3'b000, m_fl});
        chk({tag, " rst_req"}, {7'b0, rst_req}, {7'b0, m_req});
    endtask

    task automatic idle(input int n, input logic t, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, t, 4'h0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1957));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset ctrl", ctrl_rd, 8'h00);
        chk("R1 reset stat", stat_rd, 8'h00);
        chk("R1 reset rst_req", {7'b0, rst_req}, 8'h00);

        // R2/R3/R12: plain write enables, cannot move select, ie and bit 7 behave
        step(1, 0, 8'hCF, 0, 0, 0, "R3 locked write");
        chk("R3 locked fields", ctrl_rd, 8'h48);
        step(1, 0, 8'h00, 0, 0, 0, "R3 clear en refused");
        chk("R12 ie cleared, en kept", ctrl_rd, 8'h08);

        // R7/R10: code 0 times out after 4 ticks
        idle(3, 1, "R7 counting");
        chk("R7 no early request", {7'b0, rst_req}, 8'h00);
        idle(1, 1, "R7 terminal tick");
        chk("R7 request due", {7'b0, rst_req}, 8'h01);
        chk("R10 flag set", stat_rd, 8'h08);
        idle(1, 1, "R7 pulse ends");
        chk("R7 single pulse", {7'b0, rst_req}, 8'h00);

        // R8: kick on the terminal tick prevents the request
        idle(2, 1, "R8 count");
        step(0, 0, 0, 1, 1, 0, "R8 kick wins");
        chk("R8 no request after kick", {7'b0, rst_req}, 8'h00);

        // R10: write-zero clears, write-one keeps
        step(1, 1, 8'hF7, 0, 0, 0, "R10 clear flag");
        chk("R10 flag cleared", stat_rd, 8'h00);

        // R4/R5: arm, then commit on the fourth edge
        step(1, 0, 8'h18, 0, 0, 0, "R4 arm");
        chk("R4 ce visible", ctrl_rd, 8'h18);
        idle(3, 0, "R6 window");
        step(1, 0, 8'h05, 0, 0, 0, "R5 commit at edge 4");
        chk("R5 accepted", ctrl_rd, 8'h05);

        // R6: commit on the fifth edge is ignored
        step(1, 0, 8'h18, 0, 0, 0, "R4 arm again");
        idle(4, 0, "R6 expire");
        chk("R6 ce cleared", ctrl_rd, 8'h0D);
        step(1, 0, 8'h02, 0, 0, 0, "R6 late commit");
        chk("R6 late ignored", ctrl_rd, 8'h0D);

        // R12: abort keeps enable and select
        step(1, 0, 8'h18, 0, 0, 0, "R12 arm");
        step(1, 0, 8'h10, 0, 0, 0, "R12 abort");
        chk("R12 abort unchanged", ctrl_rd, 8'h0D);

        // R9: reserved code 15 behaves as code 9 (2048 ticks)
        step(1, 0, 8'h18, 0, 0, 0, "R9 arm");
        step(1, 0, 8'h2F, 0, 0, 0, "R9 commit code 15");
        idle(2047, 1, "R9 long count");
        chk("R9 no early request", {7'b0, rst_req}, 8'h00);
        idle(1, 1, "R9 terminal");
        chk("R9 request at 2048", {7'b0, rst_req}, 8'h01);

        // R11: other causes
        step(0, 0, 0, 0, 0, 4'hF, "R11 causes");
        chk("R11 cause flags", stat_rd, 8'h1F);

        // random phase checked against the model
        for (int i = 0; i < 6000; i++) begin
            logic w, s, k, t;
            logic [7:0] dd;
            logic [3:0] c;
            w = ($urandom % 6) == 0;
            s = ($urandom % 4) == 0;
            dd = 8'($urandom);
            if (w && !s && ($urandom % 3 == 0)) dd = dd | 8'h18;
            if (w && !s && ($urandom % 2 == 0)) dd[5] = 1'b0;
            k = ($urandom % 50) == 0;
            t = ($urandom % 4) != 0;
            c = (($urandom % 200) == 0) ? 4'($urandom) : 4'h0;
            step(w, s, dd, k, t, c, "R2-model random");
        end
        finish_run();
    end
endmodule